// File: doc/BRIEF.md
# Core Countdown Timer

The block is a per-core timer clocked from a constant time base. A 64-bit configuration word holds a run bit, a repeat bit and a start count. Writing the word with the run bit set loads the start count into a down-counter. The counter then loses one unit on every time-base tick. When it runs out, the block raises a level interrupt. In repeat mode the counter reloads from the start count and keeps going. In single mode the block clears the run bit in its own stored configuration and stops.

A second counter runs freely beside the countdown. It reports the number of ticks since reset and is not affected by configuration writes. Software reads the configuration word, the free-running count or the remaining ticks through a two-bit read select. It acknowledges the interrupt with a one-cycle clear pulse. The parameter `TICK_DIV` sets how many clock cycles make one tick. With the default of 1, every clock cycle is a tick.

Top module: `core_timer`

## Requirements
- R1: After reset the configuration reads 0, the remaining-tick value reads 0 and `irq_o` is low.
- R2: The free-running counter (read select 1) equals the number of ticks since reset deassertion and does not change on configuration writes.
- R3: The start count is the written word with bits 1:0 and bits 63:48 forced to zero, i.e. bits 47:2 of the word.
- R4: A configuration write with bit 0 (run) set loads the start count into the countdown at that clock edge, replacing any countdown in progress. Expiry happens on the tick that would take the countdown from 1 to 0, so a start count of N expires N ticks after the write.
- R5: While running, the remaining-tick value (read select 2) falls by one per tick.
- R6: A configuration write with bit 0 clear stops the countdown. The remaining value reads 0 and no expiry follows.
- R7: On expiry with bit 1 (repeat) set, the countdown reloads the start count at once and the stored configuration is unchanged.
- R8: On expiry with bit 1 clear, bit 0 of the stored configuration clears, the other bits are kept, and the remaining value reads 0 from then on.
- R9: Every expiry sets `irq_o` one cycle later. `irq_o` stays high until a cycle with `irq_clr_i` high and no new expiry.
- R10: An expiry and `irq_clr_i` in the same cycle leave `irq_o` high.
- R11: Read select 0 returns the stored configuration word as written (apart from the bit-0 clear of R8), and read select 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | DATA_W | Configuration write data |
| rd_sel_i | input | 2 | Read select: 0 configuration, 1 free counter, 2 remaining ticks, 3 zero |
| rd_data_o | output | DATA_W | Read data, combinational from select |
| irq_clr_i | input | 1 | Interrupt clear pulse |
| irq_o | output | 1 | Level timer interrupt |

## Verification
Two pairs of events can land in the same cycle. An interrupt clear can coincide with a repeat-mode expiry. A configuration write can coincide with a tick that would otherwise decrement or expire the countdown. The bench times the clear pulse so that it is sampled on the very edge of the second periodic expiry, and expects `irq_o` to stay high with the count reloaded. It also rewrites the configuration in the middle of a running countdown and expects the remaining value to equal the new start count, not the decremented old one.

// File: rtl/core_timer_pkg.sv
package core_timer_pkg;
  localparam int RUN_BIT = 0;
  localparam int REP_BIT = 1;
  localparam int CNT_LO  = 2;

  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_FREE = 2'd1,
    SEL_REM  = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/core_timer_tick.sv
module core_timer_tick #(
  parameter int TICK_DIV = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int DW   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int LAST = (TICK_DIV > 1) ? TICK_DIV - 1 : 0;

  logic [DW-1:0] div_q;

  assign tick_o = (div_q == DW'(LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + DW'(1);
  end

  generate
    if (TICK_DIV > 1) begin : g_div_chk
      // R2
      tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/core_timer_free.sv
module core_timer_free #(
  parameter int FREE_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  output logic [FREE_W-1:0] free_o
);
  logic [FREE_W-1:0] free_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     free_q <= '0;
    else if (tick_i) free_q <= free_q + FREE_W'(1);
  end

  assign free_o = free_q;

  // R2
  free_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && free_q != '1) |=> free_q > $past(free_q));
endmodule

// File: rtl/core_timer_cdown.sv
module core_timer_cdown
  import core_timer_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CNT_HI = 47
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cfg_o,
  output logic [DATA_W-1:0] rem_o,
  output logic              expire_o
);
  function automatic logic [DATA_W-1:0] mask_gen();
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i >= CNT_LO) && (i <= CNT_HI);
    return m;
  endfunction

  localparam logic [DATA_W-1:0] INIT_MASK = mask_gen();

  logic [DATA_W-1:0] cfg_q, rem_q;
  logic              running;

  assign running  = cfg_q[RUN_BIT];
  // write wins over a tick in the same cycle
  assign expire_o = tick_i && running && !we_i && (rem_q <= DATA_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      rem_q <= '0;
    end else if (we_i) begin
      cfg_q <= wdata_i;
      rem_q <= wdata_i[RUN_BIT] ? (wdata_i & INIT_MASK) : '0;
    end else if (expire_o) begin
      if (cfg_q[REP_BIT]) begin
        rem_q <= cfg_q & INIT_MASK;
      end else begin
        rem_q          <= '0;
        cfg_q[RUN_BIT] <= 1'b0;
      end
    end else if (tick_i && running) begin
      rem_q <= rem_q - DATA_W'(1);
    end
  end

  assign cfg_o = cfg_q;
  assign rem_o = rem_q;

  // R3 R4
  restart_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i[RUN_BIT]) |=> (rem_q & ~INIT_MASK) == '0);
  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running && !we_i) |=> ($stable(rem_q) && $stable(cfg_q)));
  // R7
  reload_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && cfg_q[REP_BIT]) |=> ($stable(cfg_q) && rem_q == (cfg_q & INIT_MASK)));
  // R8
  oneshot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !cfg_q[REP_BIT]) |=> (!cfg_q[RUN_BIT] && rem_q == '0));
endmodule

// File: rtl/core_timer.sv
module core_timer
  import core_timer_pkg::*;
#(
  parameter int TICK_DIV = 1,
  parameter int DATA_W   = 64,
  parameter int FREE_W   = 64,
  parameter int CNT_HI   = 47
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic [1:0]        rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              irq_clr_i,
  output logic              irq_o
);
  logic              tick;
  logic              expire;
  logic [FREE_W-1:0] free_cnt;
  logic [DATA_W-1:0] cfg, rem;
  logic              irq_q;

  core_timer_tick #(.TICK_DIV(TICK_DIV)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  core_timer_free #(.FREE_W(FREE_W)) i_free (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .free_o (free_cnt)
  );

  core_timer_cdown #(.DATA_W(DATA_W), .CNT_HI(CNT_HI)) i_cdown (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i),
    .cfg_o    (cfg),
    .rem_o    (rem),
    .expire_o (expire)
  );

  // new expiry beats a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (expire)    irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  always_comb begin
    unique case (rd_sel_e'(rd_sel_i))
      SEL_CFG:  rd_data_o = cfg;
      SEL_FREE: rd_data_o = DATA_W'(free_cnt);
      SEL_REM:  rd_data_o = rem;
      default:  rd_data_o = '0;
    endcase
  end

  // R9
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(expire));
  // R9
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !irq_clr_i) |=> irq_q);
  // R10
  irq_clr_race_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && irq_clr_i) |=> irq_q);
  // R11
  rd_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_i == 2'd3) |-> rd_data_o == '0);
endmodule

// File: tb/test_core_timer.sv
`timescale 1ns/100ps
module test_core_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [63:0] cfg_wdata = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [63:0] rd_data;
  logic        irq_clr = 1'b0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  int unsigned edges = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;
    logic [63:0] exp;
    string       tag;
  } item_t;
  item_t q[$];
  event  chk_ev;

  always #10 clk = ~clk;

  core_timer i_core_timer (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_we_i    (cfg_we),
    .cfg_wdata_i (cfg_wdata),
    .rd_sel_i    (rd_sel),
    .rd_data_o   (rd_data),
    .irq_clr_i   (irq_clr),
    .irq_o       (irq)
  );

  always @(posedge clk) if (rst_n) edges <= edges + 1;

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [63:0] act;
        it = q.pop_front();
        act = (it.kind == 4) ? {63'd0, irq} : rd_data;
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  // kinds 0..3 are read selects, 4 is the interrupt line
  task automatic expect_item(int kind, logic [63:0] exp, string tag);
    item_t it;
    if (kind < 4) rd_sel = kind[1:0];
    #1;
    it.kind = kind;
    it.exp = exp;
    it.tag = tag;
    q.push_back(it);
    ->chk_ev;
    #1;
  endtask

  task automatic write_cfg(logic [63:0] v);
    cfg_we = 1'b1;
    cfg_wdata = v;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic clear_pulse();
    irq_clr = 1'b1;
    step();
    irq_clr = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(2);
    rst_n = 1'b1;
    // R1 reset state
    expect_item(0, 64'd0, "R1 cfg after reset");
    expect_item(2, 64'd0, "R1 remaining after reset");
    expect_item(4, 64'd0, "R1 irq after reset");
    step();
    expect_item(1, 64'(edges), "R2 free count after reset");

    // one-shot, start count 8
    write_cfg(64'h9);
    expect_item(2, 64'd8, "R4 one-shot load");
    expect_item(4, 64'd0, "R9 irq low before expiry");
    step(3);
    expect_item(2, 64'd5, "R5 decrement");
    step(4);
    expect_item(2, 64'd1, "R5 last tick");
    expect_item(4, 64'd0, "R4 no early expiry");
    step();
    expect_item(4, 64'd1, "R9 irq on one-shot expiry");
    expect_item(0, 64'h8, "R8 run bit cleared");
    expect_item(2, 64'd0, "R8 remaining zero");
    step(3);
    expect_item(4, 64'd1, "R9 irq held");
    expect_item(2, 64'd0, "R8 stays stopped");
    expect_item(0, 64'h8, "R8 cfg kept");
    clear_pulse();
    expect_item(4, 64'd0, "R9 clear");
    expect_item(1, 64'(edges), "R2 free count after writes");

    // periodic, start count 4
    write_cfg(64'h7);
    expect_item(2, 64'd4, "R4 periodic load");
    step(3);
    expect_item(2, 64'd1, "R5 periodic count");
    expect_item(4, 64'd0, "R9 no irq yet");
    step();
    expect_item(4, 64'd1, "R9 periodic expiry irq");
    expect_item(2, 64'd4, "R7 reload");
    expect_item(0, 64'h7, "R7 cfg unchanged");
    clear_pulse();
    expect_item(4, 64'd0, "R9 clear after periodic");
    expect_item(2, 64'd3, "R7 running after reload");
    step(2);
    expect_item(2, 64'd1, "R5 before second expiry");
    clear_pulse();
    expect_item(4, 64'd1, "R10 clear with expiry");
    expect_item(2, 64'd4, "R7 second reload");

    // stop
    clear_pulse();
    write_cfg(64'h6);
    expect_item(2, 64'd0, "R6 remaining after stop");
    expect_item(0, 64'h6, "R11 cfg readback");
    step(10);
    expect_item(4, 64'd0, "R6 no expiry after stop");
    expect_item(2, 64'd0, "R6 remaining held");

    // masking
    write_cfg(64'hFFFF_0000_0000_0107);
    expect_item(2, 64'h104, "R3 masked start count");
    expect_item(0, 64'hFFFF_0000_0000_0107, "R11 full cfg readback");
    step(2);
    expect_item(2, 64'h102, "R5 masked count runs");

    // restart mid-count
    write_cfg(64'h11);
    step(5);
    expect_item(2, 64'hB, "R5 count before rewrite");
    write_cfg(64'hD);
    expect_item(2, 64'hC, "R4 rewrite restarts");
    step(11);
    expect_item(2, 64'd1, "R5 restarted count");
    expect_item(4, 64'd0, "R4 no expiry before N ticks");
    step();
    expect_item(4, 64'd1, "R4 expiry N ticks after rewrite");
    expect_item(0, 64'hC, "R8 one-shot after rewrite");
    step();
    expect_item(1, 64'(edges), "R2 free count at end");
    expect_item(3, 64'd0, "R11 select 3 reads zero");

    step();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule